// File: doc/BRIEF.md
# Distributed Self-Selecting Bus Arbiter

This block resolves ownership of a shared bus among several masters without any central controller. Each master has its own identical arbitration node. A node holds a unique arbitration number and a request input. All nodes share three wired-OR lines: a number bus that is W bits wide, a round line and a hold line. In the top module the wired-OR is a plain OR of every node's drive vector. Every node follows the bus on its own and decides on its own whether it has lost. The nodes still stay in step, because they all leave reset together and all see the same shared lines.

A round begins on a clock edge where the round line and the hold line are both low. Every node that is requesting at that edge and has a nonzero number joins the round. During the round, each contender drives its full number onto the bus. The bits are resolved one per cycle, starting with the most significant bit. When a contender's own bit is 0 and the bus bit is 1, it withdraws. It stops driving its number from the next cycle, but it keeps the round line up until the round ends. The survivors always agree on every bit already resolved, so after exactly W cycles the largest number wins. The winner's node then owns the bus, raises its grant output and leaves only its own number on the bus. It holds ownership until its request drops. Losing nodes keep their requests and compete again in the next round, which starts one cycle after the hold line falls.

Each node has four states:
- `ND_IDLE`: not taking part.
- `ND_ARB`: contending at bit index `bit_q`.
- `ND_OUT`: out of the contest but still timing the round.
- `ND_OWN`: owning the bus.

The transitions are:
- `ND_IDLE` to `ND_ARB` (join) at an idle edge while requesting with a nonzero number.
- `ND_ARB` to `ND_ARB` (next bit) while it still contends and bits remain.
- `ND_ARB` to `ND_OUT` (withdraw) on a lost bit or a dropped request while bits remain.
- `ND_ARB` to `ND_OWN` (win) on the last bit with no loss.
- `ND_ARB` to `ND_IDLE` (lose at last bit).
- `ND_OUT` to `ND_OUT` (count down).
- `ND_OUT` to `ND_IDLE` (round over).
- `ND_OWN` to `ND_IDLE` (release) when its request drops.

Top module: `dsa_fabric`

## Requirements
- R1: After reset, grant is all zero, round_active and bus_held are low, and arb_num is zero.
- R2: A round starts only on an edge where neither a round nor an owner is present, and round_active then stays high for exactly W consecutive cycles.
- R3: The grant bit of the node with the largest number among the round's participants rises on the W-th edge after the start edge, which is the edge that ends the round.
- R4: At most one bit of grant is high in any cycle.
- R5: While node i is granted, bus_held is high and arb_num equals node i's number, which is read from node_ids bits [i*W +: W].
- R6: A granted node keeps its grant while its request stays high, and its grant falls on the first edge after its request goes low.
- R7: A node that lost keeps competing without re-requesting. The next round starts on the second edge after the owner's request drops, so the new grant arrives W+2 edges after that drop.
- R8: A request that arrives while a round is running does not join that round. It waits for the next idle edge.
- R9: A node whose number is 0 never joins a round and is never granted. Its request alone never raises round_active.
- R10: A node whose request drops during its round stops driving its number from the next cycle, and the round still runs its full length. When no contender remains, the round ends with no grant and arb_num returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Bus request of each master |
| node_ids | input | N*W | Arbitration number of each node, node i in bits [i*W +: W], unique when nonzero |
| grant | output | N | Bus ownership of each master |
| arb_num | output | W | Sensed value of the wired-OR number bus |
| round_active | output | 1 | Sensed round line, high while a round is running |
| bus_held | output | 1 | Sensed hold line, high while some node owns the bus |

## Verification
The bench targets the following corner cases:
- Numbers that differ only in their low bits, such as 15 against 14 and 13 against 12. A design that compares the wrong bit, or resolves bits in the wrong order, grants the wrong master here.
- A request raised one cycle into a running round. A design that lets late arrivals join would hand the bus to the later, higher number.
- A chain of hand-overs, each timed to the exact edge. An off-by-one in the round counter or in the restart rule shows up as a grant on the wrong cycle.
- A node numbered 0 that requests forever. A faulty design would start empty rounds or grant it.
- A requester that abandons its round. Its number must leave the bus at once, and a faulty design would grant it anyway or cut the round short.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    // Per-node arbitration state
    typedef enum logic [1:0] {
        ND_IDLE = 2'd0,   // not taking part
        ND_ARB  = 2'd1,   // contending, resolving one bit per cycle
        ND_OUT  = 2'd2,   // withdrawn, still timing the round
        ND_OWN  = 2'd3    // owns the bus
    } node_st_t;

endpackage

// File: rtl/dsa_wor.sv
// Wired-OR of N drive vectors, each DW bits wide.
module dsa_wor #(
    parameter int N  = 4,
    parameter int DW = 6
) (
    input  logic [N*DW-1:0] drv_flat,
    output logic [DW-1:0]   sensed
);

    always_comb begin
        sensed = '0;
        for (int i = 0; i < N; i++) begin
            sensed = sensed | drv_flat[i*DW +: DW];
        end
    end

endmodule

// File: rtl/dsa_node.sv
// One self-selecting arbitration node.
module dsa_node
    import dsa_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic [W-1:0] my_id,
    input  logic [W-1:0] bus_num,
    input  logic         bus_round,
    input  logic         bus_hold,
    output logic [W-1:0] drv_num,
    output logic         drv_round,
    output logic         drv_hold,
    output logic         grant
);

    localparam int              CW      = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0]   TOP_BIT = CW'(W - 1);

    node_st_t      st, st_n;
    logic [CW-1:0] bit_q, bit_n;
    logic          id_valid;
    logic          bit_lost;
    logic          last_bit;
    logic          bus_idle;

    assign id_valid = |my_id;
    assign bit_lost = bus_num[bit_q] & ~my_id[bit_q];
    assign last_bit = (bit_q == '0);
    assign bus_idle = ~bus_round & ~bus_hold;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ND_IDLE;
            bit_q <= '0;
        end else begin
            st    <= st_n;
            bit_q <= bit_n;
        end
    end

    // Next-state logic
    always_comb begin
        st_n  = st;
        bit_n = bit_q;
        unique case (st)
            ND_IDLE: begin
                if (req && id_valid && bus_idle) begin
                    st_n  = ND_ARB;
                    bit_n = TOP_BIT;
                end
            end
            ND_ARB: begin
                if (last_bit) begin
                    st_n = (req && !bit_lost) ? ND_OWN : ND_IDLE;
                end else begin
                    bit_n = bit_q - 1'b1;
                    if (!req || bit_lost) begin
                        st_n = ND_OUT;
                    end
                end
            end
            ND_OUT: begin
                if (last_bit) begin
                    st_n = ND_IDLE;
                end else begin
                    bit_n = bit_q - 1'b1;
                end
            end
            ND_OWN: begin
                if (!req) begin
                    st_n = ND_IDLE;
                end
            end
            default: st_n = ND_IDLE;
        endcase
    end

    // Output logic: drives onto the shared lines
    always_comb begin
        drv_num   = '0;
        drv_round = 1'b0;
        drv_hold  = 1'b0;
        grant     = 1'b0;
        unique case (st)
            ND_IDLE: begin
            end
            ND_ARB: begin
                drv_num   = my_id;
                drv_round = 1'b1;
            end
            ND_OUT: begin
                drv_round = 1'b1;
            end
            ND_OWN: begin
                drv_num  = my_id;
                drv_hold = 1'b1;
                grant    = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dsa_fabric.sv
// N arbitration nodes on one wired-OR number/round/hold bus.
module dsa_fabric #(
    parameter int N = 4,
    parameter int W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req,
    input  logic [N*W-1:0] node_ids,
    output logic [N-1:0]   grant,
    output logic [W-1:0]   arb_num,
    output logic           round_active,
    output logic           bus_held
);

    localparam int BW = W + 2;   // {hold, round, number}

    logic [N*BW-1:0] drv_flat;
    logic [BW-1:0]   bus_sense;

    assign arb_num      = bus_sense[W-1:0];
    assign round_active = bus_sense[W];
    assign bus_held     = bus_sense[W+1];

    for (genvar g = 0; g < N; g++) begin : g_node
        logic [W-1:0] d_num;
        logic         d_round;
        logic         d_hold;

        dsa_node #(.W(W)) u_node (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req[g]),
            .my_id     (node_ids[g*W +: W]),
            .bus_num   (arb_num),
            .bus_round (round_active),
            .bus_hold  (bus_held),
            .drv_num   (d_num),
            .drv_round (d_round),
            .drv_hold  (d_hold),
            .grant     (grant[g])
        );

        assign drv_flat[g*BW +: BW] = {d_hold, d_round, d_num};
    end

    dsa_wor #(.N(N), .DW(BW)) u_wor (
        .drv_flat (drv_flat),
        .sensed   (bus_sense)
    );

endmodule

// File: rtl/dsa_fabric_chk.sv
module dsa_fabric_chk #(
    parameter int N = 4,
    parameter int W = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   req,
    input logic [N*W-1:0] node_ids,
    input logic [N-1:0]   grant,
    input logic [W-1:0]   arb_num,
    input logic           round_active,
    input logic           bus_held
);

    localparam int LW = $clog2(W + 1) + 1;

    logic [LW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n)            run_len <= '0;
        else if (round_active) run_len <= run_len + 1'b1;
        else                   run_len <= '0;
    end

    // R2
    round_not_overlong_chk: assert property (@(posedge clk) disable iff (!rst_n)
        round_active |-> (run_len < LW'(W)));

    // R2
    round_full_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(round_active) |-> ($past(run_len) == LW'(W - 1)));

    // R4
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3
    grant_from_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|grant) |-> $past(round_active));

    // R3
    no_round_while_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> !round_active);

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R5
        owner_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> (bus_held && arb_num == node_ids[i*W +: W]));

        // R6
        grant_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && req[i]) |=> grant[i]);

        // R6
        grant_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && !req[i]) |=> !grant[i]);

        // R9
        zero_id_never_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (node_ids[i*W +: W] == '0) |-> !grant[i]);
    end

endmodule

bind dsa_fabric dsa_fabric_chk #(.N(N), .W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .node_ids     (node_ids),
    .grant        (grant),
    .arb_num      (arb_num),
    .round_active (round_active),
    .bus_held     (bus_held)
);

// File: tb/sim_dsa_fabric.sv
module sim_dsa_fabric;

    localparam int N = 4;
    localparam int W = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req = '0;
    logic [N*W-1:0] ids = '0;
    logic [N-1:0]   grant;
    logic [W-1:0]   arb_num;
    logic           round_active;
    logic           bus_held;

    always #10 clk = ~clk;   // 50 MHz

    dsa_fabric #(.N(N), .W(W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .node_ids     (ids),
        .grant        (grant),
        .arb_num      (arb_num),
        .round_active (round_active),
        .bus_held     (bus_held)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        int idx;
        int at;
    } exp_t;
    exp_t sb[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic set_ids(input int a, input int b, input int c, input int d);
        ids[0*W +: W] = W'(a);
        ids[1*W +: W] = W'(b);
        ids[2*W +: W] = W'(c);
        ids[3*W +: W] = W'(d);
    endtask

    // lead = edges until the round starts (1 from idle, 2 after a release)
    task automatic expect_win(input int idx, input int lead);
        exp_t e;
        e.idx = idx;
        e.at  = cyc + lead + W;
        sb.push_back(e);
    endtask

    task automatic wait_sb();
        int t = 0;
        while (sb.size() != 0 && t < 200) begin
            @(negedge clk);
            #1;
            t++;
        end
        check(sb.size() == 0, "R3", "expected grant never seen", sb.size(), 0);
    endtask

    // Monitor: pops an expectation for every new grant
    initial begin
        logic [N-1:0] prev;
        prev = '0;
        forever begin
            @(negedge clk);
            if (rst_n && grant != prev && grant != '0) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4", "unexpected grant", int'(grant), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(grant == (N'(1) << e.idx), "R3", "granted node",
                          int'(grant), 1 << e.idx);
                    check(cyc == e.at, "R3", "grant cycle", cyc, e.at);
                end
            end
            prev = grant;
        end
    end

    initial begin
        int cnt;
        set_ids(5, 12, 3, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(grant == '0, "R1", "grant after reset", int'(grant), 0);
        check(arb_num == '0, "R1", "arb_num after reset", int'(arb_num), 0);
        check(!round_active, "R1", "round after reset", int'(round_active), 0);
        check(!bus_held, "R1", "hold after reset", int'(bus_held), 0);

        // Single requester, round length and ownership
        req[0] = 1'b1;
        expect_win(0, 1);
        cnt = 0;
        repeat (W + 2) begin
            @(negedge clk);
            cnt += int'(round_active);
        end
        check(cnt == W, "R2", "round length", cnt, W);
        wait_sb();
        check(arb_num == 4'd5, "R5", "owner number on bus", int'(arb_num), 5);
        check(bus_held, "R5", "hold line", int'(bus_held), 1);
        repeat (3) @(negedge clk);
        check(grant == 4'b0001, "R6", "grant kept", int'(grant), 1);
        req[0] = 1'b0;
        @(negedge clk);
        check(grant == '0, "R6", "grant released", int'(grant), 0);
        check(!bus_held, "R6", "hold released", int'(bus_held), 0);

        // All request: largest number wins, losers retry in order
        req = 4'b1111;
        expect_win(1, 1);
        wait_sb();
        check(arb_num == 4'd12, "R5", "owner number 12", int'(arb_num), 12);
        req[1] = 1'b0;
        expect_win(0, 2);
        wait_sb();
        check(arb_num == 4'd5, "R7", "loser retried", int'(arb_num), 5);
        req[0] = 1'b0;
        expect_win(2, 2);
        wait_sb();
        req[2] = 1'b0;
        cnt = 0;
        repeat (3 * W) begin
            @(negedge clk);
            cnt += int'(round_active) + int'(grant != '0);
        end
        check(cnt == 0, "R9", "zero number idle", cnt, 0);
        req[3] = 1'b0;

        // Late arrival waits for the next round
        req[2] = 1'b1;
        expect_win(2, 1);
        @(negedge clk);
        req[1] = 1'b1;
        wait_sb();
        check(grant == 4'b0100, "R8", "late joiner excluded", int'(grant), 4);
        req[2] = 1'b0;
        expect_win(1, 2);
        wait_sb();
        req[1] = 1'b0;
        @(negedge clk);

        // Abandoned round
        req[0] = 1'b1;
        @(negedge clk);
        check(arb_num == 4'd5, "R10", "contender on bus", int'(arb_num), 5);
        req[0] = 1'b0;
        @(negedge clk);
        check(arb_num == '0, "R10", "number withdrawn", int'(arb_num), 0);
        check(round_active, "R10", "round continues", int'(round_active), 1);
        repeat (W) @(negedge clk);
        check(grant == '0 && !round_active, "R10", "no owner after round",
              int'(grant), 0);
        check(arb_num == '0, "R10", "bus empty", int'(arb_num), 0);

        // Second number set
        set_ids(9, 6, 14, 1);
        req = 4'b1011;
        expect_win(0, 1);
        wait_sb();
        req[0] = 1'b0;
        expect_win(1, 2);
        wait_sb();
        req[1] = 1'b0;
        expect_win(3, 2);
        wait_sb();
        req[3] = 1'b0;
        @(negedge clk);

        // Numbers differing only in low bits
        set_ids(14, 15, 13, 12);
        req = 4'b1111;
        expect_win(1, 1);
        wait_sb();
        req[1] = 1'b0;
        expect_win(0, 2);
        wait_sb();
        req[0] = 1'b0;
        expect_win(2, 2);
        wait_sb();
        req[2] = 1'b0;
        expect_win(3, 2);
        wait_sb();
        req[3] = 1'b0;
        repeat (2) @(negedge clk);
        check(grant == '0, "R6", "final release", int'(grant), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule